// File: doc/BRIEF.md
# Synchronous SRAM Port Select and Strobe Controller

This block is the access-control front end of a flowthrough synchronous SRAM port. On every rising clock edge it samples three chip-select inputs, two address strobes and a write request. From these it decides whether a new access starts, the current access carries on, or the port drops into the deselected state. Its outputs tell the array whether the current cycle is a live access and whether that access is a write. Because the port is flowthrough, read data for the address taken at one edge is presented during the following cycle. The cycle that follows the edge is therefore the one these outputs qualify.

The block also produces the per-lane drive enables for the three-state data bus. The active-low output-enable input reaches those enables without passing through a register. The bus is driven only in read cycles. It stays released in the first read cycle that follows a deselected or dozing period, and also during writes and while the port is deselected.

A doze input lets the port rest with its contents intact. While doze is high the port reports no access and ignores both strobes. After doze falls, the port remains deselected until a strobe is accepted.

States of the controller:
- ST_IDLE: deselected.
- ST_RD_FIRST: first read cycle after ST_IDLE or ST_DOZE. The bus stays released.
- ST_RD: read cycle, with the bus driven when out_en_n is low.
- ST_WR: write cycle.
- ST_DOZE: resting.

Transitions, evaluated at each rising edge:
- doze high leads to ST_DOZE from any state.
- An accepted strobe while the port is not selected leads to ST_IDLE (deselect).
- An accepted read start leads to ST_RD_FIRST from ST_IDLE or ST_DOZE, and to ST_RD from any active state.
- An accepted write start leads to ST_WR.
- With no accepted strobe, an active state continues. It goes to ST_WR when wr_req_n is low and to ST_RD otherwise.
- With no accepted strobe, ST_IDLE and ST_DOZE go to ST_IDLE.

Top module: `sram_port_ctl`

## Requirements
- R1: A new access begins only on an edge where sel_a_n=0, sel_b=1 and sel_c_n=0 and a strobe is accepted. acc_vld goes high in the cycle after that edge.
- R2: host_stb_n is ignored on any edge where sel_a_n=1. With ctrl_stb_n high an active access continues and an idle port stays idle. With ctrl_stb_n low the controller strobe alone decides the outcome.
- R3: An accepted host strobe (host_stb_n=0 with sel_a_n=0) always starts a read, whatever wr_req_n is. When both strobes are low on the same edge, only the host strobe is acted on.
- R4: An accepted strobe on an edge where the select condition of R1 is false deselects the port: acc_vld=0 and acc_wr=0 in the next cycle.
- R5: A controller strobe acting alone on a selected edge starts a write (acc_wr=1) when wr_req_n=0 and a read (acc_wr=0) when wr_req_n=1.
- R6: On an edge with no accepted strobe, an active access continues with acc_vld=1 and its type taken from wr_req_n (0 = write). A deselected port stays deselected.
- R7: In a read cycle that is not a first read cycle, every bit of bus_drive equals the inverse of out_en_n and follows it with no clock edge in between.
- R8: In the first read cycle after ST_IDLE or ST_DOZE, bus_drive is all zeros even when out_en_n=0. A read started from an active access is not masked.
- R9: bus_drive is all zeros while the port is deselected and during write cycles.
- R10: A doze level of 1 sampled at an edge gives acc_vld=0 in the next cycle, and strobes are ignored while doze is high. After doze falls the port stays deselected until a strobe is accepted.
- R11: While rst_n is low the port is deselected: acc_vld=0, acc_wr=0 and bus_drive all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_a_n | input | 1 | Chip select A, active low; also qualifies the host strobe |
| sel_b | input | 1 | Chip select B, active high |
| sel_c_n | input | 1 | Chip select C, active low |
| host_stb_n | input | 1 | Host (processor-side) address strobe, active low, higher priority |
| ctrl_stb_n | input | 1 | Controller-side address strobe, active low |
| wr_req_n | input | 1 | Write request, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| doze | input | 1 | Rest request, active high |
| acc_vld | output | 1 | Current cycle is a live access |
| acc_wr | output | 1 | Current access is a write |
| bus_drive | output | LANES | Per-lane data bus drive enable |

## Verification
The bench builds the block with its default LANES of 4. Each bus_drive lane is therefore compared against an all-ones or all-zeros expectation, so a lane that drifts from its neighbours is caught. With that width the bench reaches every state and every edge of the transition list. That includes the host strobe with sel_a_n high both alone and paired with the controller strobe, a read start from an active access compared with one from idle, and the recovery after doze. Toggling out_en_n in the middle of a cycle in ST_RD exposes any register placed on the output-enable path.

// File: rtl/sram_port_ctl_pkg.sv
package sram_port_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_FIRST,
        ST_RD,
        ST_WR,
        ST_DOZE
    } ctl_state_t;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_DESEL,
        CMD_START_RD,
        CMD_START_WR
    } ctl_cmd_t;

endpackage

// File: rtl/sram_port_ctl_decode.sv
module sram_port_ctl_decode
    import sram_port_ctl_pkg::*;
(
    input  logic     sel_a_n,
    input  logic     sel_b,
    input  logic     sel_c_n,
    input  logic     host_stb_n,
    input  logic     ctrl_stb_n,
    input  logic     wr_req_n,
    output ctl_cmd_t cmd
);

    logic selected;
    logic host_take;
    logic ctrl_take;

    assign selected  = !sel_a_n && sel_b && !sel_c_n;
    // host strobe only counts while select A is asserted
    assign host_take = !host_stb_n && !sel_a_n;
    assign ctrl_take = !ctrl_stb_n;

    always_comb begin
        cmd = CMD_NONE;
        if (host_take) begin
            cmd = selected ? CMD_START_RD : CMD_DESEL;
        end else if (ctrl_take) begin
            if (!selected)
                cmd = CMD_DESEL;
            else if (!wr_req_n)
                cmd = CMD_START_WR;
            else
                cmd = CMD_START_RD;
        end
    end

endmodule

// File: rtl/sram_port_ctl_fsm.sv
module sram_port_ctl_fsm
    import sram_port_ctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     doze,
    input  logic     wr_req_n,
    input  ctl_cmd_t cmd,
    output logic     acc_vld,
    output logic     acc_wr,
    output logic     rd_live
);

    ctl_state_t state_q;
    ctl_state_t state_d;
    logic       resting;

    assign resting = (state_q == ST_IDLE) || (state_q == ST_DOZE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (doze) begin
            state_d = ST_DOZE;
        end else begin
            unique case (cmd)
                CMD_DESEL:    state_d = ST_IDLE;
                CMD_START_WR: state_d = ST_WR;
                CMD_START_RD: state_d = resting ? ST_RD_FIRST : ST_RD;
                default: begin
                    if (resting)
                        state_d = ST_IDLE;
                    else
                        state_d = wr_req_n ? ST_RD : ST_WR;
                end
            endcase
        end
    end

    always_comb begin
        acc_vld = 1'b0;
        acc_wr  = 1'b0;
        rd_live = 1'b0;
        unique case (state_q)
            ST_RD_FIRST: acc_vld = 1'b1;
            ST_RD: begin
                acc_vld = 1'b1;
                rd_live = 1'b1;
            end
            ST_WR: begin
                acc_vld = 1'b1;
                acc_wr  = 1'b1;
            end
            default: ;
        endcase
    end

    AST_WR_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr |-> acc_vld); // R6

endmodule

// File: rtl/sram_port_ctl_oe_gate.sv
module sram_port_ctl_oe_gate #(
    parameter int LANES = 4
) (
    input  logic             rd_live,
    input  logic             out_en_n,
    output logic [LANES-1:0] bus_drive
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign bus_drive[g] = rd_live && !out_en_n;
    end

endmodule

// File: rtl/sram_port_ctl.sv
module sram_port_ctl
    import sram_port_ctl_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_a_n,
    input  logic             sel_b,
    input  logic             sel_c_n,
    input  logic             host_stb_n,
    input  logic             ctrl_stb_n,
    input  logic             wr_req_n,
    input  logic             out_en_n,
    input  logic             doze,
    output logic             acc_vld,
    output logic             acc_wr,
    output logic [LANES-1:0] bus_drive
);

    localparam logic [LANES-1:0] NO_DRIVE = '0;

    ctl_cmd_t cmd;
    logic     rd_live;

    sram_port_ctl_decode u_decode (
        .sel_a_n    (sel_a_n),
        .sel_b      (sel_b),
        .sel_c_n    (sel_c_n),
        .host_stb_n (host_stb_n),
        .ctrl_stb_n (ctrl_stb_n),
        .wr_req_n   (wr_req_n),
        .cmd        (cmd)
    );

    sram_port_ctl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .doze     (doze),
        .wr_req_n (wr_req_n),
        .cmd      (cmd),
        .acc_vld  (acc_vld),
        .acc_wr   (acc_wr),
        .rd_live  (rd_live)
    );

    sram_port_ctl_oe_gate #(.LANES(LANES)) u_oe_gate (
        .rd_live   (rd_live),
        .out_en_n  (out_en_n),
        .bus_drive (bus_drive)
    );

    AST_START_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acc_vld) |-> $past(!sel_a_n && sel_b && !sel_c_n)); // R1

    AST_HOST_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!doze && sel_a_n && !host_stb_n && ctrl_stb_n && !acc_vld) |=> !acc_vld); // R2

    AST_HOST_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (!doze && !sel_a_n && sel_b && !sel_c_n && !host_stb_n && !ctrl_stb_n)
        |=> (acc_vld && !acc_wr)); // R3

    AST_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!doze && !ctrl_stb_n && (sel_a_n || !sel_b || sel_c_n)) |=> !acc_vld); // R4

    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!doze && !sel_a_n && sel_b && !sel_c_n && host_stb_n && !ctrl_stb_n && !wr_req_n)
        |=> acc_wr); // R5

    AST_FIRST_READ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(acc_vld) && !acc_wr) |-> (bus_drive == NO_DRIVE)); // R8

    AST_NO_DRIVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_vld || acc_wr) |-> (bus_drive == NO_DRIVE)); // R9

    AST_DOZE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        doze |=> !acc_vld); // R10

endmodule

// File: tb/sram_port_ctl_tb.sv
`timescale 1ns/1ps
module sram_port_ctl_tb;

    localparam int LANES = 4;

    typedef struct {
        logic  vld;
        logic  wr;
        logic  drv;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
    logic host_stb_n = 1'b1, ctrl_stb_n = 1'b1, wr_req_n = 1'b1;
    logic out_en_n = 1'b1, doze = 1'b0;
    logic acc_vld, acc_wr;
    logic [LANES-1:0] bus_drive;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t sb[$];

    always #2 clk = ~clk;

    sram_port_ctl #(.LANES(LANES)) u_dut (
        .clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
        .sel_c_n(sel_c_n), .host_stb_n(host_stb_n), .ctrl_stb_n(ctrl_stb_n),
        .wr_req_n(wr_req_n), .out_en_n(out_en_n), .doze(doze),
        .acc_vld(acc_vld), .acc_wr(acc_wr), .bus_drive(bus_drive)
    );

    task automatic check_now(input string tag, input logic ev, input logic ew, input logic ed);
        logic [LANES-1:0] edrv;
        edrv = {LANES{ed}};
        checks++;
        if (acc_vld !== ev || acc_wr !== ew || bus_drive !== edrv) begin
            errors++;
            $display("FAIL %s actual vld=%0b wr=%0b drive=%b expected vld=%0b wr=%0b drive=%b",
                     tag, acc_vld, acc_wr, bus_drive, ev, ew, edrv);
        end
    endtask

    // driver: apply inputs before an edge, queue the outputs due after it
    task automatic step(input logic a, input logic b, input logic c,
                        input logic hs, input logic cs, input logic wr,
                        input logic oe, input logic dz,
                        input logic ev, input logic ew, input logic ed, input string tag);
        exp_t item;
        @(negedge clk);
        sel_a_n = a; sel_b = b; sel_c_n = c;
        host_stb_n = hs; ctrl_stb_n = cs; wr_req_n = wr;
        out_en_n = oe; doze = dz;
        item.vld = ev; item.wr = ew; item.drv = ed; item.tag = tag;
        sb.push_back(item);
    endtask

    // monitor: compare one queued item 1 ns after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t it;
                it = sb.pop_front();
                check_now(it.tag, it.vld, it.wr, it.drv);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R11 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_now("R11 reset", 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        //    a  b  c  hs cs wr oe dz   vld wr drv
        step(0, 1, 0, 1, 1, 1, 0, 0,   0, 0, 0, "R6 idle stays idle");
        step(0, 1, 0, 1, 0, 1, 0, 0,   1, 0, 0, "R8 R1 ctrl read first masked");
        step(0, 1, 0, 1, 1, 1, 0, 0,   1, 0, 1, "R6 R7 continue read drives");
        step(0, 1, 0, 1, 1, 1, 1, 0,   1, 0, 0, "R7 out_en_n high releases");
        step(0, 1, 0, 1, 1, 0, 0, 0,   1, 1, 0, "R6 R9 continue as write");
        step(0, 0, 0, 1, 0, 1, 0, 0,   0, 0, 0, "R4 R9 ctrl strobe sel_b low");
        step(0, 1, 0, 0, 1, 0, 0, 0,   1, 0, 0, "R3 host read despite wr_req_n");
        step(0, 1, 0, 1, 0, 1, 0, 0,   1, 0, 1, "R8 read from active unmasked");
        step(1, 1, 0, 0, 1, 1, 0, 0,   1, 0, 1, "R2 host ignored access continues");
        step(1, 1, 0, 0, 0, 1, 0, 0,   0, 0, 0, "R2 ctrl strobe decides deselect");
        step(1, 1, 0, 0, 1, 1, 0, 0,   0, 0, 0, "R2 host ignored idle stays");
        step(0, 1, 0, 0, 0, 0, 0, 0,   1, 0, 0, "R3 both strobes host wins");
        step(0, 1, 0, 1, 0, 0, 0, 0,   1, 1, 0, "R5 ctrl write from active");
        step(0, 1, 1, 1, 0, 1, 0, 0,   0, 0, 0, "R4 R1 sel_c_n high deselects");
        step(0, 1, 0, 1, 0, 0, 0, 0,   1, 1, 0, "R5 ctrl write from idle");
        step(0, 1, 0, 1, 0, 1, 0, 1,   0, 0, 0, "R10 doze blocks strobe");
        step(0, 1, 0, 0, 1, 1, 0, 1,   0, 0, 0, "R10 doze host ignored");
        step(0, 1, 0, 1, 1, 1, 0, 0,   0, 0, 0, "R10 after doze still idle");
        step(0, 1, 0, 1, 0, 1, 0, 0,   1, 0, 0, "R10 R8 resume first read masked");
        step(0, 1, 0, 1, 1, 1, 0, 0,   1, 0, 1, "R7 read drives again");
        @(posedge clk);
        #1.5;
        out_en_n = 1'b1;
        #0.2;
        check_now("R7 async release mid-cycle", 1'b1, 1'b0, 1'b0);
        out_en_n = 1'b0;
        #0.2;
        check_now("R7 async drive mid-cycle", 1'b1, 1'b0, 1'b1);
        repeat (2) @(posedge clk);
        #1.5;
        rst_n = 1'b0;
        #0.2;
        check_now("R11 async reset", 1'b0, 1'b0, 1'b0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule